// File: doc/BRIEF.md
# Shared DRAM Time-Slot Sequencer

This block drives the row and column strobes of a DRAM that a video fetch engine and a CPU share. A 16 MHz master clock steps a sixteen-phase frame, so one frame lasts 1 µs. The first half of the frame belongs to the video engine. In that half the row strobe stays low once while the column strobe falls twice, which gives two page-mode reads. The second half belongs to the CPU. Its row strobe always opens, but the column strobe falls only when the CPU requested memory and the cycle is not a refresh cycle.

Alongside the strobes, the block reports which side owns the current slot. It also produces a READY level for CPU wait states, built as an AND of one phase bit with the inverse of another. A one-clock enable pulses four times per frame, which clocks the CPU at 4 MHz, so one CPU access spans four CPU clocks. Every output is registered and decoded from the next phase, so each output moves exactly on the clock edge that enters its phase.

The phases are enumerated states that advance one step per clock in a fixed ring: PH_V_PRE(0) → PH_V_RAS(1) → PH_V_CAS0A(2) → PH_V_CAS0B(3) → PH_V_GAP(4) → PH_V_CAS1A(5) → PH_V_CAS1B(6) → PH_V_TAIL(7) → PH_C_PRE(8) → PH_C_RAS(9) → PH_C_SMP(10) → PH_C_CAS0(11) → PH_C_CAS1(12) → PH_C_CAS2(13) → PH_C_END(14) → PH_C_IDLE(15) → PH_V_PRE(0). There is no other transition. Synchronous reset forces PH_V_PRE.

Top module: `dram_slot_seq`

## Requirements
- R1: While `rst` is high, the frame is held in phase 0. The outputs then read `ras_n`=1, `cas_n`=1, `vid_own`=1, `cpu_ready`=0 and `cpu_clk_en`=0. The first rising edge with `rst` low enters phase 1.
- R2: The phase advances by one on every rising edge and wraps from 15 to 0, so the output pattern repeats every 16 clocks.
- R3: `ras_n` is low in phases 1–7 and 9–14. It is high in phases 0, 8 and 15.
- R4: In the video half, `cas_n` is low in phases 2, 3, 5 and 6 and high otherwise. This gives exactly two falling edges within the video row period.
- R5: On the rising edge that enters phase 10, the block samples `mreq_n`=0 together with `rfsh_n`=1. When both hold, `cas_n` is low in phases 11–13 of that frame. Otherwise `cas_n` stays high throughout phases 8–15.
- R6: Values of `mreq_n` and `rfsh_n` at any other edge have no effect on `cas_n`.
- R7: `vid_own` is high in phases 0–7 and low in phases 8–15.
- R8: `cpu_ready` is high in phases 4–7 only, which is phase bit 2 AND NOT phase bit 3.
- R9: `cpu_clk_en` is high for one clock in phases 3, 7, 11 and 15, and low otherwise.
- R10: `cas_n` is never low while `ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| mreq_n | input | 1 | CPU memory request, active low |
| rfsh_n | input | 1 | CPU refresh indicator, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| vid_own | output | 1 | High in video slots, low in the CPU slot |
| cpu_ready | output | 1 | Wait-state control to the CPU |
| cpu_clk_en | output | 1 | One-clock enable for the 4 MHz CPU clock |

## Verification
Every output changes on the same edge that enters its phase. The bench keeps its own phase count, advances it at each rising edge and compares all five outputs at the following falling edge against values it computes from that count. The CPU request inputs are held inverted except during the single clock before the edge into phase 10. The column strobe result therefore shows up one and three edges later, in phases 11–13, and it is judged against the values the bench latched at that edge. Column-strobe falls are counted over each half-frame and checked at phases 8 and 15. A mid-frame reset is checked on the first falling edge after it is applied.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

    localparam int PH_W      = 4;
    localparam int PH_N      = 1 << PH_W;
    localparam int CKEN_LOG2 = 2;

    typedef enum logic [PH_W-1:0] {
        PH_V_PRE   = 4'd0,
        PH_V_RAS   = 4'd1,
        PH_V_CAS0A = 4'd2,
        PH_V_CAS0B = 4'd3,
        PH_V_GAP   = 4'd4,
        PH_V_CAS1A = 4'd5,
        PH_V_CAS1B = 4'd6,
        PH_V_TAIL  = 4'd7,
        PH_C_PRE   = 4'd8,
        PH_C_RAS   = 4'd9,
        PH_C_SMP   = 4'd10,
        PH_C_CAS0  = 4'd11,
        PH_C_CAS1  = 4'd12,
        PH_C_CAS2  = 4'd13,
        PH_C_END   = 4'd14,
        PH_C_IDLE  = 4'd15
    } phase_e;

endpackage

// File: rtl/dram_slot_fsm.sv
module dram_slot_fsm
    import dram_slot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase_q,
    output phase_e phase_d
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_V_PRE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        if (rst) begin
            phase_d = PH_V_PRE;
        end else begin
            unique case (phase_q)
                PH_V_PRE:   phase_d = PH_V_RAS;
                PH_V_RAS:   phase_d = PH_V_CAS0A;
                PH_V_CAS0A: phase_d = PH_V_CAS0B;
                PH_V_CAS0B: phase_d = PH_V_GAP;
                PH_V_GAP:   phase_d = PH_V_CAS1A;
                PH_V_CAS1A: phase_d = PH_V_CAS1B;
                PH_V_CAS1B: phase_d = PH_V_TAIL;
                PH_V_TAIL:  phase_d = PH_C_PRE;
                PH_C_PRE:   phase_d = PH_C_RAS;
                PH_C_RAS:   phase_d = PH_C_SMP;
                PH_C_SMP:   phase_d = PH_C_CAS0;
                PH_C_CAS0:  phase_d = PH_C_CAS1;
                PH_C_CAS1:  phase_d = PH_C_CAS2;
                PH_C_CAS2:  phase_d = PH_C_END;
                PH_C_END:   phase_d = PH_C_IDLE;
                PH_C_IDLE:  phase_d = PH_V_PRE;
            endcase
        end
    end

endmodule

// File: rtl/dram_slot_decode.sv
module dram_slot_decode
    import dram_slot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_d,
    input  logic   mreq_n,
    input  logic   rfsh_n,
    output logic   ras_n,
    output logic   cas_n,
    output logic   vid_own,
    output logic   cpu_ready,
    output logic   cpu_clk_en
);

    logic grant_q;
    logic ras_d;
    logic vcas_d;
    logic cwin_d;
    logic own_d;
    logic rdy_d;
    logic cken_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
        end else if (phase_d == PH_C_SMP) begin
            grant_q <= ~mreq_n & rfsh_n;
        end
    end

    always_comb begin
        ras_d  = 1'b1;
        vcas_d = 1'b1;
        cwin_d = 1'b0;
        own_d  = 1'b1;
        unique case (phase_d)
            PH_V_PRE: begin
            end
            PH_V_RAS, PH_V_GAP, PH_V_TAIL: begin
                ras_d = 1'b0;
            end
            PH_V_CAS0A, PH_V_CAS0B, PH_V_CAS1A, PH_V_CAS1B: begin
                ras_d  = 1'b0;
                vcas_d = 1'b0;
            end
            PH_C_PRE, PH_C_IDLE: begin
                own_d = 1'b0;
            end
            PH_C_RAS, PH_C_SMP, PH_C_END: begin
                ras_d = 1'b0;
                own_d = 1'b0;
            end
            PH_C_CAS0, PH_C_CAS1, PH_C_CAS2: begin
                ras_d  = 1'b0;
                own_d  = 1'b0;
                cwin_d = 1'b1;
            end
        endcase
        rdy_d  = phase_d[2] & ~phase_d[3];
        cken_d = &phase_d[CKEN_LOG2-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_n      <= 1'b1;
            cas_n      <= 1'b1;
            vid_own    <= 1'b1;
            cpu_ready  <= 1'b0;
            cpu_clk_en <= 1'b0;
        end else begin
            ras_n      <= ras_d;
            cas_n      <= vcas_d & ~(cwin_d & grant_q);
            vid_own    <= own_d;
            cpu_ready  <= rdy_d;
            cpu_clk_en <= cken_d;
        end
    end

endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
    import dram_slot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mreq_n,
    input  logic rfsh_n,
    output logic ras_n,
    output logic cas_n,
    output logic vid_own,
    output logic cpu_ready,
    output logic cpu_clk_en
);

    phase_e phase_q;
    phase_e phase_d;

    dram_slot_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .phase_d (phase_d)
    );

    dram_slot_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .phase_d    (phase_d),
        .mreq_n     (mreq_n),
        .rfsh_n     (rfsh_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .vid_own    (vid_own),
        .cpu_ready  (cpu_ready),
        .cpu_clk_en (cpu_clk_en)
    );

endmodule

// File: rtl/dram_slot_seq_chk.sv
module dram_slot_seq_chk (
    input logic clk,
    input logic rst,
    input logic mreq_n,
    input logic rfsh_n,
    input logic ras_n,
    input logic cas_n,
    input logic vid_own,
    input logic cpu_ready,
    input logic cpu_clk_en
);

    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n) else $error("cas_n low with ras_n high"); // R10

    AST_CLK_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |=> !cpu_clk_en) else $error("cpu_clk_en held two cycles"); // R9

    AST_READY_IN_VIDEO: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> vid_own) else $error("cpu_ready outside video half"); // R8

    AST_RAS_HIGH_AT_SWAP: assert property (@(posedge clk) disable iff (rst)
        $fell(vid_own) |-> ras_n) else $error("ras_n low at CPU slot start"); // R3

    AST_RAS_HIGH_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(vid_own) |-> ras_n) else $error("ras_n low at frame start"); // R3

    AST_CPU_CAS_GATED: assert property (@(posedge clk) disable iff (rst)
        (!vid_own && $fell(cas_n)) |-> $past(!mreq_n && rfsh_n, 2))
        else $error("CPU column strobe without request"); // R5

endmodule

bind dram_slot_seq dram_slot_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mreq_n     (mreq_n),
    .rfsh_n     (rfsh_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .vid_own    (vid_own),
    .cpu_ready  (cpu_ready),
    .cpu_clk_en (cpu_clk_en)
);

// File: tb/dram_slot_seq_tb.sv
`timescale 1ns/1ps
module dram_slot_seq_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mreq_n = 1'b1;
    logic rfsh_n = 1'b1;
    logic ras_n, cas_n, vid_own, cpu_ready, cpu_clk_en;

    int checks = 0;
    int errors = 0;
    int p = 0;
    bit g_exp = 1'b0;
    bit prev_cas = 1'b1;
    int falls = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dram_slot_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .mreq_n     (mreq_n),
        .rfsh_n     (rfsh_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .vid_own    (vid_own),
        .cpu_ready  (cpu_ready),
        .cpu_clk_en (cpu_clk_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s phase=%0d actual=%0d expected=%0d", req, p, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        bit e_ras, e_cas, e_own, e_rdy, e_ck;
        e_ras = !((p >= 1 && p <= 7) || (p >= 9 && p <= 14));
        e_cas = !(p == 2 || p == 3 || p == 5 || p == 6 || (g_exp && p >= 11 && p <= 13));
        e_own = (p < 8);
        e_rdy = (p >= 4 && p <= 7);
        e_ck  = ((p % 4) == 3);
        chk({tag, " R3 ras_n"}, ras_n, e_ras);
        chk({tag, " R4/R5/R6 cas_n"}, cas_n, e_cas);
        chk({tag, " R7 vid_own"}, vid_own, e_own);
        chk({tag, " R8 cpu_ready"}, cpu_ready, e_rdy);
        chk({tag, " R9 cpu_clk_en"}, cpu_clk_en, e_ck);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            p = 0;
            g_exp = 1'b0;
        end else begin
            p = (p + 1) % 16;
            if (p == 10) g_exp = !mreq_n && rfsh_n;
        end
        @(negedge clk);
        if (prev_cas && !cas_n) falls++;
        prev_cas = cas_n;
        check_outputs(rst ? "R1" : "R2");
        if (!rst && p == 8) begin
            chk("R4 video CAS falls", falls, 2);
            falls = 0;
        end
        if (!rst && p == 15) begin
            chk("R5 CPU CAS falls", falls, g_exp ? 1 : 0);
            falls = 0;
        end
    endtask

    initial begin
        rst = 1'b1;
        step();
        step();
        chk("R1 reset ras_n", ras_n, 1);
        chk("R1 reset cas_n", cas_n, 1);
        rst = 1'b0;
        falls = 0;
        prev_cas = 1'b1;
        step();
        chk("R1 first phase ras_n low", ras_n, 0);
        for (int f = 0; f < 8; f++) begin
            bit want_m, want_r;
            want_m = f[0];
            want_r = f[1];
            while (p != 0) step();
            mreq_n = !want_m;
            rfsh_n = !want_r;
            while (p != 9) step();
            mreq_n = want_m;
            rfsh_n = want_r;
            step();
            mreq_n = !want_m;
            rfsh_n = !want_r;
            while (p != 15) step();
        end
        while (p != 5) step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        falls = 0;
        prev_cas = cas_n;
        for (int i = 0; i < 20; i++) step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired phase=%0d actual=0 expected=1", p);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule